// File: doc/BRIEF.md
# Region Density Vector Epoch Tracker

This block watches the stream of cache miss fills coming back from memory and keeps, for each of a small number of recently touched 4 KB regions, a 64-bit mark vector with one bit per 64-byte cache block. Every fill marks its block. An epoch of a region ends when a fill arrives for a block that is already marked in that region's vector. A timer or an eviction never ends an epoch. On that repeat fill the finished vector is published, and a fresh vector holding only the repeated block starts the next epoch.

Each published vector comes with three measures computed in a short pipeline: the number of marked blocks, the length of the longest unbroken run of marked blocks, and the agreement (count of equal bit positions) with the vector the same region published last. A prefetch filter or a profiling unit can use these to judge how dense and how repeatable a region's access pattern is. Region slots sit in a fully associative table with least-recently-used replacement. A displaced region loses its partial vector and its history without publishing anything.

Top module: `density_epoch_tracker`

## Requirements
- R1: A fill address splits as region number = address bits [47:12] and block index = address bits [11:6]; address bits [5:0] have no effect on any output.
- R2: A fill to a block not yet marked in its region's current vector only marks it; no completion pulse follows.
- R3: A fill to an already marked block closes the epoch: the published vector is the one before this fill, and the next epoch starts with only that block marked.
- R4: A closing fill sampled at clock edge N gives a completion pulse lasting exactly one cycle, registered at edge N+2, and carrying the region number of that fill.
- R5: The reported population count equals the number of set bits in the published vector (1 to 64).
- R6: The reported longest run equals the longest contiguous string of set bits and never exceeds the population count.
- R7: The reported similarity equals 64 minus the number of differing bits between the published vector and that region's previously published vector, and reads 0 when the region has none.
- R8: Epochs of different regions are independent; fills to one region never mark, close or alter another region's vector.
- R9: Four regions are tracked at once; a fill to a fifth region replaces the least recently filled one, whose partial vector and history are dropped unpublished.
- R10: With no fill presented, no completion pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fillValid | input | 1 | A miss fill is presented this cycle |
| fillAddr | input | 48 | Physical address of the fill |
| doneValid | output | 1 | One-cycle pulse: a completed vector is presented |
| doneRegion | output | 36 | Region number of the completed vector |
| doneVector | output | 64 | Completed mark vector, bit i = block i |
| donePop | output | 7 | Number of set bits |
| doneRun | output | 7 | Longest run of set bits |
| doneSim | output | 7 | Agreeing bit positions versus the previous vector of the region, 0 if none |

## Verification
The hardest situation to reach is a region that loses its slot to replacement and then comes back. A stale hit there would look like a correct close. The stimulus opens five regions in a known recency order. It then revisits a displaced region with a block it had marked before displacement, and expects no pulse. A second repeat must then close with only that block marked and a similarity of 0, which shows the history went with the slot. A full 64-block sweep followed by a repeat drives the counts to their maximum.

// File: rtl/dvt_pkg.sv
package dvt_pkg;
  localparam int ADDR_W       = 48;
  localparam int REGION_SHIFT = 12;
  localparam int BLOCK_SHIFT  = 6;
  localparam int TRACK_N      = 4;

  localparam int IDX_W = REGION_SHIFT - BLOCK_SHIFT;
  localparam int VEC_W = 1 << IDX_W;
  localparam int RGN_W = ADDR_W - REGION_SHIFT;
  localparam int WAY_W = (TRACK_N > 1) ? $clog2(TRACK_N) : 1;
  localparam int CNT_W = IDX_W + 1;

  // Strobes from control to datapath for one fill
  typedef struct packed {
    logic             touch;   // a fill updates slot `way`
    logic             alloc;   // slot is (re)allocated to a new region
    logic             close;   // repeat fill: publish and restart
    logic [WAY_W-1:0] way;
    logic [IDX_W-1:0] bitIdx;
    logic [RGN_W-1:0] region;
  } dvStrobe_t;
endpackage

// File: rtl/dvt_ctrl.sv
module dvt_ctrl
  import dvt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fillValid,
  input  logic [ADDR_W-1:0]  fillAddr,
  input  logic [TRACK_N-1:0] wayMarked,
  output dvStrobe_t          strobe
);
  logic [TRACK_N-1:0] tagValid;
  logic [RGN_W-1:0]   tagRgn [TRACK_N];
  logic [WAY_W-1:0]   age    [TRACK_N];

  logic [RGN_W-1:0]   fillRgn;
  logic [IDX_W-1:0]   fillBit;
  logic [TRACK_N-1:0] hitVec;
  logic               hitAny;
  logic [WAY_W-1:0]   hitWay;
  logic [WAY_W-1:0]   victim;
  logic               foundFree;
  logic [WAY_W-1:0]   selWay;

  assign fillRgn = fillAddr[ADDR_W-1:REGION_SHIFT];
  assign fillBit = fillAddr[REGION_SHIFT-1:BLOCK_SHIFT];

  for (genvar g = 0; g < TRACK_N; g++) begin : g_match
    assign hitVec[g] = tagValid[g] && (tagRgn[g] == fillRgn);
  end

  assign hitAny = |hitVec;

  always_comb begin
    hitWay    = '0;
    victim    = '0;
    foundFree = 1'b0;
    for (int i = 0; i < TRACK_N; i++) begin
      if (hitVec[i]) hitWay = WAY_W'(i);
    end
    for (int i = TRACK_N - 1; i >= 0; i--) begin
      if (!tagValid[i]) begin
        victim    = WAY_W'(i);
        foundFree = 1'b1;
      end
    end
    if (!foundFree) begin
      for (int i = 0; i < TRACK_N; i++) begin
        if (age[i] == WAY_W'(TRACK_N - 1)) victim = WAY_W'(i);
      end
    end
  end

  assign selWay = hitAny ? hitWay : victim;

  always_comb begin
    strobe.touch  = fillValid;
    strobe.alloc  = fillValid && !hitAny;
    strobe.close  = fillValid && hitAny && wayMarked[hitWay];
    strobe.way    = selWay;
    strobe.bitIdx = fillBit;
    strobe.region = fillRgn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tagValid <= '0;
      for (int i = 0; i < TRACK_N; i++) begin
        tagRgn[i] <= '0;
        age[i]    <= WAY_W'(i);
      end
    end else if (fillValid) begin
      tagValid[selWay] <= 1'b1;
      tagRgn[selWay]   <= fillRgn;
      for (int i = 0; i < TRACK_N; i++) begin
        if (WAY_W'(i) == selWay)       age[i] <= '0;
        else if (age[i] < age[selWay]) age[i] <= age[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dvt_datapath.sv
module dvt_datapath
  import dvt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  dvStrobe_t          strobe,
  output logic [TRACK_N-1:0] wayMarked,
  output logic               doneValid,
  output logic [RGN_W-1:0]   doneRegion,
  output logic [VEC_W-1:0]   doneVector,
  output logic [CNT_W-1:0]   donePop,
  output logic [CNT_W-1:0]   doneRun,
  output logic [CNT_W-1:0]   doneSim
);
  logic [VEC_W-1:0] curVec  [TRACK_N];
  logic [VEC_W-1:0] prevVec [TRACK_N];
  logic [TRACK_N-1:0] hasPrev;

  logic [VEC_W-1:0] fillMask;
  assign fillMask = VEC_W'(1) << strobe.bitIdx;

  for (genvar g = 0; g < TRACK_N; g++) begin : g_mark
    assign wayMarked[g] = curVec[g][strobe.bitIdx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hasPrev <= '0;
      for (int i = 0; i < TRACK_N; i++) begin
        curVec[i]  <= '0;
        prevVec[i] <= '0;
      end
    end else if (strobe.touch) begin
      if (strobe.alloc) begin
        curVec[strobe.way]  <= fillMask;
        prevVec[strobe.way] <= '0;
        hasPrev[strobe.way] <= 1'b0;
      end else if (strobe.close) begin
        prevVec[strobe.way] <= curVec[strobe.way];
        hasPrev[strobe.way] <= 1'b1;
        curVec[strobe.way]  <= fillMask;
      end else begin
        curVec[strobe.way]  <= curVec[strobe.way] | fillMask;
      end
    end
  end

  // Stage 1: capture the finished vector and its predecessor
  logic             s1Valid;
  logic [RGN_W-1:0] s1Rgn;
  logic [VEC_W-1:0] s1Vec;
  logic [VEC_W-1:0] s1Prev;
  logic             s1HasPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid   <= 1'b0;
      s1Rgn     <= '0;
      s1Vec     <= '0;
      s1Prev    <= '0;
      s1HasPrev <= 1'b0;
    end else begin
      s1Valid <= strobe.close;
      if (strobe.close) begin
        s1Rgn     <= strobe.region;
        s1Vec     <= curVec[strobe.way];
        s1Prev    <= prevVec[strobe.way];
        s1HasPrev <= hasPrev[strobe.way];
      end
    end
  end

  // Stage 2: counts over the captured vector
  logic [CNT_W-1:0] popCnt, runBest, runCur, diffCnt;
  logic [VEC_W-1:0] diffVec;
  assign diffVec = s1Vec ^ s1Prev;

  always_comb begin
    popCnt  = '0;
    diffCnt = '0;
    runBest = '0;
    runCur  = '0;
    for (int i = 0; i < VEC_W; i++) begin
      popCnt  = popCnt + CNT_W'(s1Vec[i]);
      diffCnt = diffCnt + CNT_W'(diffVec[i]);
      runCur  = s1Vec[i] ? runCur + 1'b1 : '0;
      if (runCur > runBest) runBest = runCur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneValid  <= 1'b0;
      doneRegion <= '0;
      doneVector <= '0;
      donePop    <= '0;
      doneRun    <= '0;
      doneSim    <= '0;
    end else begin
      doneValid <= s1Valid;
      if (s1Valid) begin
        doneRegion <= s1Rgn;
        doneVector <= s1Vec;
        donePop    <= popCnt;
        doneRun    <= runBest;
        doneSim    <= s1HasPrev ? CNT_W'(VEC_W) - diffCnt : '0;
      end
    end
  end
endmodule

// File: rtl/density_epoch_tracker.sv
module density_epoch_tracker
  import dvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  output logic              doneValid,
  output logic [RGN_W-1:0]  doneRegion,
  output logic [VEC_W-1:0]  doneVector,
  output logic [CNT_W-1:0]  donePop,
  output logic [CNT_W-1:0]  doneRun,
  output logic [CNT_W-1:0]  doneSim
);
  dvStrobe_t          strobe;
  logic [TRACK_N-1:0] wayMarked;

  dvt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fillValid (fillValid),
    .fillAddr  (fillAddr),
    .wayMarked (wayMarked),
    .strobe    (strobe)
  );

  dvt_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .wayMarked  (wayMarked),
    .doneValid  (doneValid),
    .doneRegion (doneRegion),
    .doneVector (doneVector),
    .donePop    (donePop),
    .doneRun    (doneRun),
    .doneSim    (doneSim)
  );
endmodule

// File: rtl/dvt_checker.sv
module dvt_checker
  import dvt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fillValid,
  input logic [ADDR_W-1:0] fillAddr,
  input logic              doneValid,
  input logic [RGN_W-1:0]  doneRegion,
  input logic [VEC_W-1:0]  doneVector,
  input logic [CNT_W-1:0]  donePop,
  input logic [CNT_W-1:0]  doneRun,
  input logic [CNT_W-1:0]  doneSim
);
  AST_PULSE_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> $past(fillValid, 2)); // R10
  AST_REGION_OF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> doneRegion == RGN_W'($past(fillAddr, 2) >> REGION_SHIFT)); // R4
  AST_REPEAT_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> doneVector[$past(fillAddr[REGION_SHIFT-1:BLOCK_SHIFT], 2)]); // R3
  AST_POP_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> donePop == CNT_W'($countones(doneVector))); // R5
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> (doneRun <= donePop) && (doneRun != '0)); // R6
  AST_SIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> doneSim <= CNT_W'(VEC_W)); // R7
endmodule

bind density_epoch_tracker dvt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fillValid  (fillValid),
  .fillAddr   (fillAddr),
  .doneValid  (doneValid),
  .doneRegion (doneRegion),
  .doneVector (doneVector),
  .donePop    (donePop),
  .doneRun    (doneRun),
  .doneSim    (doneSim)
);

// File: tb/density_epoch_tracker_tb.sv
`timescale 1ns/1ps
module density_epoch_tracker_tb;
  import dvt_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fillValid = 1'b0;
  logic [ADDR_W-1:0] fillAddr = '0;
  logic              doneValid;
  logic [RGN_W-1:0]  doneRegion;
  logic [VEC_W-1:0]  doneVector;
  logic [CNT_W-1:0]  donePop, doneRun, doneSim;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  density_epoch_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .fillValid(fillValid), .fillAddr(fillAddr),
    .doneValid(doneValid), .doneRegion(doneRegion), .doneVector(doneVector),
    .donePop(donePop), .doneRun(doneRun), .doneSim(doneSim)
  );

  localparam logic [RGN_W-1:0] RG_A = 36'h12345;
  localparam logic [RGN_W-1:0] RG_B = 36'h12346;
  localparam logic [RGN_W-1:0] RG_C = 36'hABCDE;
  localparam logic [RGN_W-1:0] RG_D = 36'h00001;
  localparam logic [RGN_W-1:0] RG_E = 36'hFFFFFFFFF;

  function automatic logic [ADDR_W-1:0] mk(input logic [RGN_W-1:0] r, input int blk, input logic [5:0] off);
    return {r, 6'(blk), off};
  endfunction

  function automatic int ones(input logic [63:0] v);
    int n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int longRun(input logic [63:0] v);
    int best = 0;
    int cur = 0;
    for (int i = 0; i < 64; i++) begin
      cur = v[i] ? cur + 1 : 0;
      if (cur > best) best = cur;
    end
    return best;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Present one fill at a negedge; check the cycle after (no pulse) and
  // the cycle two edges later (pulse iff a close is expected).
  task automatic doFill(input logic [ADDR_W-1:0] a, input bit expClose,
                        input logic [63:0] expVec, input logic [63:0] expPrev,
                        input bit expHasPrev, input string req);
    int expSim;
    fillAddr  = a;
    fillValid = 1'b1;
    @(negedge clk);
    fillValid = 1'b0;
    check(doneValid == 1'b0, "R4", "pulse one cycle early", 64'(doneValid), 64'd0);
    @(negedge clk);
    check(doneValid == expClose, req, "completion pulse", 64'(doneValid), 64'(expClose));
    if (expClose && doneValid) begin
      expSim = expHasPrev ? 64 - ones(expVec ^ expPrev) : 0;
      check(doneRegion == a[ADDR_W-1:REGION_SHIFT], "R4", "region", 64'(doneRegion), 64'(a[ADDR_W-1:REGION_SHIFT]));
      check(doneVector == expVec, req, "vector", doneVector, expVec);
      check(int'(donePop) == ones(expVec), "R5", "population", 64'(donePop), 64'(ones(expVec)));
      check(int'(doneRun) == longRun(expVec), "R6", "longest run", 64'(doneRun), 64'(longRun(expVec)));
      check(int'(doneSim) == expSim, "R7", "similarity", 64'(doneSim), 64'(expSim));
    end
  endtask

  task automatic tResetState();
    check(doneValid == 1'b0, "R10", "valid after reset", 64'(doneValid), 64'd0);
    repeat (3) @(negedge clk);
    check(doneValid == 1'b0, "R10", "idle no pulse", 64'(doneValid), 64'd0);
  endtask

  // R1 R2 R3: marks ignore low offset bits; repeat of block 2 closes {0,2,3}
  task automatic tFirstEpoch();
    doFill(mk(RG_A, 2, 6'h2B), 0, '0, '0, 0, "R2");
    doFill(mk(RG_A, 0, 6'h3F), 0, '0, '0, 0, "R2");
    doFill(mk(RG_A, 3, 6'h01), 0, '0, '0, 0, "R1");
    doFill(mk(RG_A, 2, 6'h00), 1, 64'h0D, '0, 0, "R3");
  endtask

  // R3 R7: new epoch starts with block 2 only; closes {2,5,6,7} vs 0x0D
  task automatic tSecondEpoch();
    doFill(mk(RG_A, 5, 6'h10), 0, '0, '0, 0, "R2");
    doFill(mk(RG_A, 7, 6'h00), 0, '0, '0, 0, "R2");
    doFill(mk(RG_A, 6, 6'h05), 0, '0, '0, 0, "R2");
    doFill(mk(RG_A, 6, 6'h00), 1, 64'hE4, 64'h0D, 1, "R3");
  endtask

  // R8: adjacent region B keeps its own epoch
  task automatic tIndependent();
    doFill(mk(RG_B, 1, 6'h00), 0, '0, '0, 0, "R8");
    doFill(mk(RG_A, 1, 6'h00), 0, '0, '0, 0, "R8");
    doFill(mk(RG_B, 1, 6'h08), 1, 64'h02, '0, 0, "R8");
    doFill(mk(RG_A, 6, 6'h00), 1, 64'h42, 64'hE4, 1, "R8");
  endtask

  // R5 R6: all 64 blocks marked, then a repeat
  task automatic tFullVector();
    for (int b = 0; b < 64; b++) doFill(mk(RG_C, b, 6'h00), 0, '0, '0, 0, "R2");
    doFill(mk(RG_C, 0, 6'h00), 1, {64{1'b1}}, '0, 0, "R5");
  endtask

  // R9: recency A,B order is B < A < C; D fills the free slot, E evicts B,
  // B returns (evicting A) with no stale history.
  task automatic tReplacement();
    doFill(mk(RG_D, 0, 6'h00), 0, '0, '0, 0, "R9");
    doFill(mk(RG_E, 0, 6'h00), 0, '0, '0, 0, "R9");
    doFill(mk(RG_B, 1, 6'h00), 0, '0, '0, 0, "R9");
    doFill(mk(RG_B, 1, 6'h00), 1, 64'h02, '0, 0, "R9");
    doFill(mk(RG_A, 6, 6'h00), 0, '0, '0, 0, "R9");
    doFill(mk(RG_D, 0, 6'h00), 1, 64'h01, '0, 0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tResetState();
    tFirstEpoch();
    tSecondEpoch();
    tIndependent();
    tFullVector();
    tReplacement();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule